// File: doc/BRIEF.md
# Packed 16-bit Lane Shifter

This execution unit treats a register-wide operand (XLEN bits, 32 or 64 by parameter) as a row of independent 16-bit lanes. It shifts every lane by the same amount. The amount comes either from the low bits of a second register operand or from a 4-bit immediate. The unit can shift right arithmetically or logically, either truncating or rounding. It can shift left, either wrapping or saturating. It also has a combined mode in which the sign of a 5-bit amount picks a saturating left shift or an arithmetic right shift.

An operation is presented with `inValid` for one cycle. The result appears, registered, on the following cycle together with `resValid`. The unit keeps a sticky saturation flag. Any lane that saturates sets the flag. The flag stays set until the surrounding logic pulses `satClear`. Instruction decode and register writeback belong to the surrounding pipeline.

Top module: `simd16_shift_unit`

## Requirements
- R1: The operand is split into XLEN/16 lanes, and lane k occupies bits 16k+15:16k. Every lane uses the same amount and is computed independently. The result and `resValid` appear on the clock edge after the edge that samples `inValid` high.
- R2: When `useImm` is 1, the amount is `immAmt`. Otherwise the amount is taken from `rs2Data`: bits 3:0 for operation codes 0 to 5, and bits 4:0 for codes 6 and 7. All higher bits of `rs2Data` have no effect on the result.
- R3: Code 0 is an arithmetic right shift, which fills vacated bits with the lane's bit 15. Code 2 is a logical right shift, which fills them with zeros.
- R4: Code 1 is the rounding form of code 0, and code 3 is the rounding form of code 2. Each adds bit (amount-1) of the original lane to the shifted lane. An amount of 0 returns the lane unchanged.
- R5: Code 4 shifts left and discards the bits that move past bit 15.
- R6: Code 5 is a saturating left shift. A lane overflows when the amount exceeds the number of bits just below bit 15 that equal bit 15. An overflowing lane becomes 0x8000 if it was negative and 0x7FFF otherwise.
- R7: `satFlag` goes to 1 on the edge after any valid operation in which some lane overflowed. It stays at 1 until `satClear` is sampled high, and then it reads 0 on the next edge. A clear in the same cycle as an overflow also leaves the flag at 0.
- R8: Codes 6 and 7 read the amount as a signed 5-bit value. A value of 0 or more performs the code 5 behaviour. A negative value performs an arithmetic right shift by its magnitude, with a magnitude of 16 treated as 15. Code 7 rounds that right shift as in R4. With `useImm` set, the amount is the non-negative `immAmt`.
- R9: After reset, `resData`, `resValid` and `satFlag` are 0. `resData` holds its value in every cycle where `inValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 3 | Operation code, 0 to 7 (see R3 to R8) |
| useImm | input | 1 | Take the amount from immAmt |
| immAmt | input | 4 | Immediate shift amount |
| rs1Data | input | XLEN | Packed lanes to shift |
| rs2Data | input | XLEN | Register shift amount source |
| satClear | input | 1 | Clears the sticky saturation flag |
| resValid | output | 1 | Result valid |
| resData | output | XLEN | Packed shifted lanes |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
The clocked properties assume that `rstN` is held low until `inValid` and `satClear` are settled low. They also assume that every control input is driven to a known value on every cycle after reset. The bench keeps within this. It holds all inputs at 0 through reset. It changes inputs only on the falling clock edge. It presents each operation for exactly one cycle and then returns `inValid` to 0. The flag properties also rely on `satClear` being a single-cycle pulse that the bench issues separately from operations. A clear and an overflow in the same cycle are tested once, on purpose.

// File: rtl/simd16_shift_pkg.sv
package simd16_shift_pkg;

  localparam int LANE_W = 16;
  localparam int AMT_W  = 4;

  typedef enum logic [2:0] {
    OP_SRA      = 3'd0,
    OP_SRA_RND  = 3'd1,
    OP_SRL      = 3'd2,
    OP_SRL_RND  = 3'd3,
    OP_SLL      = 3'd4,
    OP_SLL_SAT  = 3'd5,
    OP_SLRA     = 3'd6,
    OP_SLRA_RND = 3'd7
  } shift_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             clearSat;
    logic             doRight;
    logic             fillSign;
    logic             doRound;
    logic             doSat;
    logic [AMT_W-1:0] amt;
  } shift_ctrl_t;

endpackage

// File: rtl/simd16_shift_ctrl.sv
module simd16_shift_ctrl
  import simd16_shift_pkg::*;
(
  input  logic             inValid,
  input  logic [2:0]       opSel,
  input  logic             useImm,
  input  logic [AMT_W-1:0] immAmt,
  input  logic [AMT_W:0]   rs2Low,
  input  logic             satClear,
  output shift_ctrl_t      strb
);

  shift_op_e     op;
  logic [AMT_W:0] amt5;
  logic [AMT_W:0] mag;

  assign op   = shift_op_e'(opSel);
  assign amt5 = useImm ? {1'b0, immAmt} : rs2Low;
  assign mag  = '0 - amt5;

  always_comb begin
    strb          = '0;
    strb.load     = inValid;
    strb.clearSat = satClear;
    strb.amt      = amt5[AMT_W-1:0];
    unique case (op)
      OP_SRA: begin
        strb.doRight  = 1'b1;
        strb.fillSign = 1'b1;
      end
      OP_SRA_RND: begin
        strb.doRight  = 1'b1;
        strb.fillSign = 1'b1;
        strb.doRound  = 1'b1;
      end
      OP_SRL: begin
        strb.doRight = 1'b1;
      end
      OP_SRL_RND: begin
        strb.doRight = 1'b1;
        strb.doRound = 1'b1;
      end
      OP_SLL: begin
        strb.doSat = 1'b0;
      end
      OP_SLL_SAT: begin
        strb.doSat = 1'b1;
      end
      OP_SLRA, OP_SLRA_RND: begin
        if (amt5[AMT_W]) begin
          strb.doRight  = 1'b1;
          strb.fillSign = 1'b1;
          strb.doRound  = (op == OP_SLRA_RND);
          strb.amt      = mag[AMT_W] ? {AMT_W{1'b1}} : mag[AMT_W-1:0];
        end else begin
          strb.doSat = 1'b1;
        end
      end
      default: strb.doSat = 1'b0;
    endcase
  end

endmodule

// File: rtl/simd16_shift_lane.sv
module simd16_shift_lane
  import simd16_shift_pkg::*;
(
  input  logic [LANE_W-1:0] laneIn,
  input  logic              doRight,
  input  logic              fillSign,
  input  logic              doRound,
  input  logic              doSat,
  input  logic [AMT_W-1:0]  amt,
  output logic [LANE_W-1:0] laneOut,
  output logic              laneOvf
);

  logic signed [LANE_W:0]   extIn;
  logic signed [LANE_W:0]   rightRaw;
  logic        [LANE_W:0]   rightSum;
  logic        [AMT_W-1:0]  amtM1;
  logic                     roundBit;
  logic        [LANE_W-1:0] leftRaw;
  logic signed [LANE_W-1:0] leftBack;
  logic                     leftLost;

  assign extIn    = {fillSign & laneIn[LANE_W-1], laneIn};
  assign rightRaw = extIn >>> amt;
  assign amtM1    = amt - 1'b1;
  assign roundBit = doRound && (amt != '0) && laneIn[amtM1];
  assign rightSum = rightRaw + {{LANE_W{1'b0}}, roundBit};

  assign leftRaw  = laneIn << amt;
  assign leftBack = $signed(leftRaw) >>> amt;
  assign leftLost = (leftBack != $signed(laneIn));

  always_comb begin
    laneOvf = 1'b0;
    if (doRight) begin
      laneOut = rightSum[LANE_W-1:0];
    end else if (doSat && leftLost) begin
      laneOvf = 1'b1;
      laneOut = laneIn[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                 : {1'b0, {(LANE_W-1){1'b1}}};
    end else begin
      laneOut = leftRaw;
    end
  end

endmodule

// File: rtl/simd16_shift_dp.sv
module simd16_shift_dp
  import simd16_shift_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  shift_ctrl_t     strb,
  input  logic [XLEN-1:0] rs1Data,
  output logic            resValid,
  output logic [XLEN-1:0] resData,
  output logic            satFlag
);

  localparam int LANES = XLEN / LANE_W;

  logic [XLEN-1:0]  laneRes;
  logic [LANES-1:0] laneOvf;
  logic             anyOvf;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    simd16_shift_lane lane_i (
      .laneIn   (rs1Data[k*LANE_W +: LANE_W]),
      .doRight  (strb.doRight),
      .fillSign (strb.fillSign),
      .doRound  (strb.doRound),
      .doSat    (strb.doSat),
      .amt      (strb.amt),
      .laneOut  (laneRes[k*LANE_W +: LANE_W]),
      .laneOvf  (laneOvf[k])
    );
  end

  assign anyOvf = |laneOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      satFlag  <= 1'b0;
    end else begin
      resValid <= strb.load;
      if (strb.load) resData <= laneRes;
      if (strb.clearSat)                satFlag <= 1'b0;
      else if (strb.load && anyOvf)     satFlag <= 1'b1;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> resValid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(resData)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !strb.clearSat) |=> satFlag); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearSat |=> !satFlag); // R7
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> $past(strb.load)); // R6

endmodule

// File: rtl/simd16_shift_unit.sv
module simd16_shift_unit
  import simd16_shift_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       opSel,
  input  logic             useImm,
  input  logic [AMT_W-1:0] immAmt,
  input  logic [XLEN-1:0]  rs1Data,
  input  logic [XLEN-1:0]  rs2Data,
  input  logic             satClear,
  output logic             resValid,
  output logic [XLEN-1:0]  resData,
  output logic             satFlag
);

  shift_ctrl_t strb;
  logic        rs2Unused;

  assign rs2Unused = ^rs2Data[XLEN-1:AMT_W+1];

  simd16_shift_ctrl ctrl_i (
    .inValid  (inValid),
    .opSel    (opSel),
    .useImm   (useImm),
    .immAmt   (immAmt),
    .rs2Low   (rs2Data[AMT_W:0]),
    .satClear (satClear),
    .strb     (strb)
  );

  simd16_shift_dp #(.XLEN(XLEN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rs1Data  (rs1Data),
    .resValid (resValid),
    .resData  (resData),
    .satFlag  (satFlag)
  );

endmodule

// File: tb/simd16_shift_unit_tb_top.sv
`timescale 1ns/1ps
module simd16_shift_unit_tb_top;

  localparam int XLEN  = 64;
  localparam int LANES = XLEN / 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [2:0]      opSel = '0;
  logic            useImm = 1'b0;
  logic [3:0]      immAmt = '0;
  logic [XLEN-1:0] rs1Data = '0;
  logic [XLEN-1:0] rs2Data = '0;
  logic            satClear = 1'b0;
  logic            resValid;
  logic [XLEN-1:0] resData;
  logic            satFlag;

  int total = 0;
  int bad = 0;
  bit expSat = 0;

  always #2 clk = ~clk;

  simd16_shift_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .useImm(useImm), .immAmt(immAmt), .rs1Data(rs1Data),
    .rs2Data(rs2Data), .satClear(satClear), .resValid(resValid),
    .resData(resData), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference lane model: {overflow, result}
  function automatic logic [16:0] refLane(input int op, input logic [15:0] x,
                                          input logic [4:0] a5);
    int sx, ux, s, cnt;
    logic [31:0] r;
    bit sat;
    sx = int'($signed(x)); ux = int'(x); s = int'(a5[3:0]); sat = 0; r = '0;
    if ((op == 6 || op == 7) && a5[4]) begin
      s = 32 - int'(a5);
      if (s == 16) s = 15;
      r = sx >>> s;
      if (op == 7) r = r + ((sx >>> (s - 1)) & 1);
    end else if (op == 0 || op == 1) begin
      r = sx >>> s;
      if (op == 1 && s > 0) r = r + ((sx >>> (s - 1)) & 1);
    end else if (op == 2 || op == 3) begin
      r = ux >> s;
      if (op == 3 && s > 0) r = r + ((ux >> (s - 1)) & 1);
    end else if (op == 4) begin
      r = ux << s;
    end else begin
      cnt = 0;
      for (int i = 14; i >= 0; i--) begin
        if (x[i] != x[15]) break;
        cnt++;
      end
      if (s > cnt) begin
        sat = 1;
        r = x[15] ? 32'h8000 : 32'h7FFF;
      end else r = ux << s;
    end
    return {sat, r[15:0]};
  endfunction

  task automatic runOp(input string req, input int op, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] b, input logic [3:0] imm, input bit ui);
    logic [XLEN-1:0] expW;
    logic [4:0] a5;
    logic [16:0] l;
    a5 = ui ? {1'b0, imm} : b[4:0];
    expW = '0;
    for (int k = 0; k < LANES; k++) begin
      l = refLane(op, a[k*16 +: 16], a5);
      expW[k*16 +: 16] = l[15:0];
      if (l[16]) expSat = 1;
    end
    @(negedge clk);
    inValid = 1; opSel = 3'(op); rs1Data = a; rs2Data = b; immAmt = imm; useImm = ui;
    @(negedge clk);
    inValid = 0;
    check({req, " data"}, resData, expW);
    check({req, " valid R1"}, {63'd0, resValid}, 64'd1);
    check({req, " flag R7"}, {63'd0, satFlag}, {63'd0, expSat});
  endtask

  task automatic clearFlag();
    @(negedge clk); satClear = 1;
    @(negedge clk); satClear = 0; expSat = 0;
    check("R7 clear", {63'd0, satFlag}, 64'd0);
  endtask

  task automatic testReset();
    check("R9 reset data", resData, '0);
    check("R9 reset valid", {63'd0, resValid}, '0);
    check("R9 reset flag", {63'd0, satFlag}, '0);
  endtask

  task automatic testRight();
    runOp("R3 sra", 0, 64'h8000_7FFF_F0F0_1234, 64'd3, 0, 0);
    runOp("R3 srl", 2, 64'h8000_7FFF_F0F0_1234, 64'd3, 0, 0);
    runOp("R3 sra 15", 0, 64'h8000_7FFF_FFFF_0001, 64'd15, 0, 0);
    runOp("R4 sra rnd", 1, 64'h0005_FFFB_7FFF_8000, 64'd1, 0, 0);
    runOp("R4 srl rnd", 3, 64'h0005_FFFB_7FFF_8000, 64'd1, 0, 0);
    runOp("R4 rnd amt0", 1, 64'h0005_FFFB_7FFF_8000, 64'd0, 0, 0);
    check("R4 amt0 unchanged", resData, 64'h0005_FFFB_7FFF_8000);
  endtask

  task automatic testLeft();
    runOp("R5 sll", 4, 64'h8000_7FFF_00FF_1234, 64'd4, 0, 0);
    check("R5 sll explicit", resData, 64'h0000_FFF0_0FF0_2340);
    clearFlag();
    runOp("R6 sat", 5, 64'h8000_7FFF_0001_FFFF, 64'd1, 0, 0);
    check("R6 sat explicit", resData, 64'h8000_7FFF_0002_FFFE);
    clearFlag();
    runOp("R6 no ovf", 5, 64'h0000_0001_FFFF_3FFF, 64'd1, 0, 0);
    check("R6 no flag", {63'd0, satFlag}, 64'd0);
    runOp("R6 amt15", 5, 64'h0000_0001_FFFF_C000, 64'd15, 0, 0);
  endtask

  task automatic testCombined();
    clearFlag();
    runOp("R8 neg16", 6, {4{16'h8000}} ^ 64'h0000_FFFF_0000_0000, 64'h10, 0, 0);
    check("R8 neg16 explicit", resData, 64'hFFFF_0000_FFFF_FFFF);
    runOp("R8 neg16 rnd", 7, 64'h8000_7FFF_4000_0001, 64'h10, 0, 0);
    check("R8 neg16 rnd explicit", resData, 64'hFFFF_0001_0001_0000);
    runOp("R8 neg1 rnd", 7, 64'h0005_FFFB_7FFF_8000, 64'h1F, 0, 0);
    runOp("R8 pos", 6, 64'h8000_7FFF_0100_FF00, 64'h0F, 0, 0);
    runOp("R8 imm left", 6, 64'h0001_4000_8000_0003, 64'h10, 4'd2, 1);
  endtask

  task automatic testAmountSource();
    runOp("R2 imm", 0, 64'h8000_7FFF_F0F0_1234, 64'd1, 4'd5, 1);
    runOp("R2 high ignored", 0, 64'h8000_7FFF_F0F0_1234, 64'hFFFF_FFFF_FFFF_FFF3, 0, 0);
    check("R2 high explicit", resData, 64'hF000_0FFF_FE1E_0246);
    runOp("R2 bit4 ignored", 2, 64'h8000_7FFF_F0F0_1234, 64'h13, 0, 0);
  endtask

  task automatic testFlag();
    clearFlag();
    runOp("R7 set", 5, 64'h7FFF, 64'd2, 0, 0);
    runOp("R7 stays", 0, 64'h1234, 64'd1, 0, 0);
    repeat (3) @(negedge clk);
    check("R7 idle keep", {63'd0, satFlag}, 64'd1);
    @(negedge clk);
    inValid = 1; opSel = 3'd5; rs1Data = 64'h7FFF; rs2Data = 64'd3; useImm = 0; satClear = 1;
    @(negedge clk);
    inValid = 0; satClear = 0; expSat = 0;
    check("R7 clear wins", {63'd0, satFlag}, 64'd0);
  endtask

  task automatic testHold();
    logic [XLEN-1:0] keep;
    runOp("R9 pre", 2, 64'hABCD_1234_5678_9ABC, 64'd4, 0, 0);
    keep = resData;
    @(negedge clk); rs1Data = ~rs1Data; opSel = 3'd4; rs2Data = 64'd7;
    @(negedge clk);
    check("R9 hold data", resData, keep);
    check("R1 valid low", {63'd0, resValid}, 64'd0);
  endtask

  task automatic testRandom();
    logic [XLEN-1:0] a, b;
    for (int n = 0; n < 400; n++) begin
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (n % 7 == 0) a[15:0] = 16'h8000;
      if (n % 11 == 0) a[31:16] = 16'h7FFF;
      runOp("R1 random", n % 8, a, b, 4'($urandom()), (n % 5 == 0) && (n % 8 != 6));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testRight();
    testLeft();
    testCombined();
    testAmountSource();
    testFlag();
    testHold();
    testRandom();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule